// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This block collects the event flags of an SD/MMC host controller into a status register and combines them with a mask register to drive one interrupt line. Events such as a command finishing, a timeout, a CRC error, the end of a data phase, a FIFO needing service or a card coming and going arrive as one-cycle pulses. Each pulse sets a sticky bit, which stays set until software acknowledges it.

Software acknowledges a bit by writing a word with a 0 in that bit position. A 1 leaves the bit untouched, so one bit can be cleared without a read-modify-write race. A mask bit of 1 blocks its event from the interrupt line. Three live levels (command busy, write protect, card present) appear in the status word as read-only bits.

A separate 16-bit SDIO status and mask pair drives its own interrupt line. The card I/O interrupt bit of that pair is further gated by a transaction-control register.

Top module: `sdh_irq_status`

## Requirements
- R1: After reset both status registers read 0, the main mask reads 0xFFFFFFFF, the SDIO mask reads 0xFFFF, transaction control reads 0, and both interrupt outputs are low.
- R2: A pulse on a sticky event input sets the matching status bit on the next clock edge, and the bit stays set. The sticky bits are: 0 card removed, 1 card inserted, 2 response end, 3 command timeout, 4 CRC fail, 5 data timeout, 6 data end, 7 rx overflow, 8 tx underrun, 9 rx ready, 10 tx request, 11 illegal access, 12 command index error, 13 stop bit error.
- R3: A write to the status register at address 0 clears each sticky bit written as 0 and leaves each bit written as 1 unchanged.
- R4: When a clear and a new event hit the same bit in the same cycle, the bit is left set.
- R5: Status bits 14 to 31, other than the live bits, read 0 and cannot be set by events or writes. Reads of addresses 5 to 7 return 0.
- R6: Status bits 16 (command busy), 17 (write protect) and 18 (card present) follow their level inputs and are unaffected by writes.
- R7: `irq_o` is a registered level. After each clock edge it is high exactly when some sticky status bit is set and its mask bit (address 1) is 0.
- R8: The main mask at address 1 is read/write, and 1 means masked.
- R9: The SDIO status at address 2 has sticky bits 0 (card I/O interrupt), 1 and 2. They are set by pulses and cleared by writing 0, and bits 3 to 15 read 0.
- R10: `sdio_irq_o` is registered. It is high when SDIO bit 1 or 2 is pending and unmasked (mask at address 3), or when bit 0 is pending and unmasked and transaction control (address 4) holds exactly 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | Event pulses for the main status bits |
| sdio_evt_i | input | 16 | Event pulses for the SDIO status bits |
| cmd_busy_i | input | 1 | Live command-busy level |
| wr_prot_i | input | 1 | Live write-protect level |
| card_present_i | input | 1 | Live card-present level |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address: 0 status, 1 mask, 2 SDIO status, 3 SDIO mask, 4 transaction control |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read address, same map as writes |
| rd_data_o | output | 32 | Combinational read data |
| irq_o | output | 1 | Main interrupt request |
| sdio_irq_o | output | 1 | SDIO interrupt request |

## Verification
The bench targets a clear and an event landing on the same bit in the same cycle. A design that let the clear win would silently drop that event. Writes of all ones to the status register are checked: a design that did not decode the write-zero-to-clear polarity would wipe pending bits. Events on reserved lines and writes to live bits are checked: a design that did not filter them would show phantom pending bits or corrupt the level reporting. The SDIO gate is driven with transaction-control values 0, 3 and 1. A design that tested only one bit of that register, or gated all SDIO bits instead of just the I/O bit, would raise or drop the SDIO interrupt at the wrong time.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
    localparam int STAT_W  = 32;
    localparam int SDIO_W  = 16;
    localparam int ADDR_W  = 3;

    // live level positions inside the main status word
    localparam int BIT_BUSY = 16;
    localparam int BIT_WP   = 17;
    localparam int BIT_CD   = 18;

    // sticky event bits 0..13 of the main status word
    localparam logic [STAT_W-1:0] MAIN_STICKY = 32'h0000_3FFF;
    // sticky bits of the SDIO status word, bit 0 is the card I/O interrupt
    localparam logic [SDIO_W-1:0] SDIO_STICKY = 16'h0007;
    localparam int SDIO_IO_BIT = 0;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_STAT      = 3'd0,
        ADDR_MASK      = 3'd1,
        ADDR_SDIO_STAT = 3'd2,
        ADDR_SDIO_MASK = 3'd3,
        ADDR_TXN       = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/sdh_stat_reg.sv
module sdh_stat_reg #(
    parameter int          W      = 32,
    parameter logic [W-1:0] STICKY = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_data_i,
    output logic [W-1:0] stat_d_o,
    output logic [W-1:0] stat_q_o
);
    typedef struct packed {
        logic [W-1:0] stat;
    } state_t;

    state_t s_d, s_q;
    logic [W-1:0] keep;

    always_comb begin
        s_d  = s_q;
        keep = clr_we_i ? clr_data_i : '1;
        // new events win over an acknowledge in the same cycle
        s_d.stat = ((s_q.stat & keep) | evt_i) & STICKY;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stat_d_o = s_d.stat;
    assign stat_q_o = s_q.stat;
endmodule

// File: rtl/sdh_mask_reg.sv
module sdh_mask_reg #(
    parameter int           W   = 32,
    parameter logic [W-1:0] RST = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_d_o,
    output logic [W-1:0] mask_q_o
);
    typedef struct packed {
        logic [W-1:0] mask;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we_i) s_d.mask = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{mask: RST};
        else        s_q <= s_d;
    end

    assign mask_d_o = s_d.mask;
    assign mask_q_o = s_q.mask;
endmodule

// File: rtl/sdh_irq_gen.sv
module sdh_irq_gen #(
    parameter int           W       = 32,
    parameter logic [W-1:0] IRQ_BITS = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] stat_d_i,
    input  logic [W-1:0] mask_d_i,
    input  logic [W-1:0] gate_d_i,
    output logic         irq_o
);
    typedef struct packed {
        logic irq;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        // computed from next-state values so the line lines up with status
        s_d.irq = |(stat_d_i & ~mask_d_i & gate_d_i & IRQ_BITS);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_o = s_q.irq;
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
    import sdh_irq_pkg::*;
#(
    parameter int SW = STAT_W,
    parameter int DW = SDIO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SW-1:0]     evt_i,
    input  logic [DW-1:0]     sdio_evt_i,
    input  logic              cmd_busy_i,
    input  logic              wr_prot_i,
    input  logic              card_present_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [SW-1:0]     wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [SW-1:0]     rd_data_o,
    output logic              irq_o,
    output logic              sdio_irq_o
);
    localparam logic [SW-1:0] STICKY_M = SW'(MAIN_STICKY);
    localparam logic [DW-1:0] STICKY_S = DW'(SDIO_STICKY);

    typedef struct packed {
        logic [DW-1:0] txn;
    } top_state_t;

    top_state_t t_d, t_q;

    logic          we_stat, we_mask, we_sstat, we_smask, we_txn;
    logic [SW-1:0] stat_d, stat_q, mask_d, mask_q, stat_rd;
    logic [DW-1:0] sstat_d, sstat_q, smask_d, smask_q, sgate_d;

    always_comb begin
        we_stat  = wr_en_i && (wr_addr_i == ADDR_STAT);
        we_mask  = wr_en_i && (wr_addr_i == ADDR_MASK);
        we_sstat = wr_en_i && (wr_addr_i == ADDR_SDIO_STAT);
        we_smask = wr_en_i && (wr_addr_i == ADDR_SDIO_MASK);
        we_txn   = wr_en_i && (wr_addr_i == ADDR_TXN);

        t_d = t_q;
        if (we_txn) t_d.txn = wr_data_i[DW-1:0];

        // only the card I/O bit depends on transaction control
        sgate_d              = '1;
        sgate_d[SDIO_IO_BIT] = (t_d.txn == DW'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    sdh_stat_reg #(.W(SW), .STICKY(STICKY_M)) u_stat (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .clr_we_i(we_stat), .clr_data_i(wr_data_i),
        .stat_d_o(stat_d), .stat_q_o(stat_q)
    );

    sdh_mask_reg #(.W(SW), .RST('1)) u_mask (
        .clk(clk), .rst_n(rst_n), .we_i(we_mask), .wdata_i(wr_data_i),
        .mask_d_o(mask_d), .mask_q_o(mask_q)
    );

    sdh_irq_gen #(.W(SW), .IRQ_BITS(STICKY_M)) u_irq (
        .clk(clk), .rst_n(rst_n), .stat_d_i(stat_d), .mask_d_i(mask_d),
        .gate_d_i('1), .irq_o(irq_o)
    );

    sdh_stat_reg #(.W(DW), .STICKY(STICKY_S)) u_sstat (
        .clk(clk), .rst_n(rst_n), .evt_i(sdio_evt_i),
        .clr_we_i(we_sstat), .clr_data_i(wr_data_i[DW-1:0]),
        .stat_d_o(sstat_d), .stat_q_o(sstat_q)
    );

    sdh_mask_reg #(.W(DW), .RST('1)) u_smask (
        .clk(clk), .rst_n(rst_n), .we_i(we_smask), .wdata_i(wr_data_i[DW-1:0]),
        .mask_d_o(smask_d), .mask_q_o(smask_q)
    );

    sdh_irq_gen #(.W(DW), .IRQ_BITS(STICKY_S)) u_sirq (
        .clk(clk), .rst_n(rst_n), .stat_d_i(sstat_d), .mask_d_i(smask_d),
        .gate_d_i(sgate_d), .irq_o(sdio_irq_o)
    );

    always_comb begin
        stat_rd           = stat_q;
        stat_rd[BIT_BUSY] = cmd_busy_i;
        stat_rd[BIT_WP]   = wr_prot_i;
        stat_rd[BIT_CD]   = card_present_i;
        case (rd_addr_i)
            ADDR_STAT:      rd_data_o = stat_rd;
            ADDR_MASK:      rd_data_o = mask_q;
            ADDR_SDIO_STAT: rd_data_o = SW'(sstat_q);
            ADDR_SDIO_MASK: rd_data_o = SW'(smask_q);
            ADDR_TXN:       rd_data_o = SW'(t_q.txn);
            default:        rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/sdh_irq_status_chk.sv
module sdh_irq_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] evt_i,
    input logic        wr_en_i,
    input logic [2:0]  wr_addr_i,
    input logic [31:0] wr_data_i,
    input logic [2:0]  rd_addr_i,
    input logic [31:0] rd_data_o,
    input logic [31:0] stat_q,
    input logic [31:0] mask_q,
    input logic [15:0] sstat_q,
    input logic [15:0] smask_q,
    input logic [15:0] txn_q,
    input logic        irq_o,
    input logic        sdio_irq_o
);
    localparam logic [31:0] STK = 32'h0000_3FFF;
    logic [31:0] clr_bits;
    assign clr_bits = (wr_en_i && wr_addr_i == 3'd0) ? ~wr_data_i : 32'h0;

    AST_RESET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mask_q == 32'hFFFF_FFFF && smask_q == 16'hFFFF)); // R1
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((stat_q & $past(evt_i) & STK) == ($past(evt_i) & STK))); // R4
    AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(stat_q) & ~$past(clr_bits) & ~stat_q) == 32'h0)); // R3
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i == 3'd0) |-> ((rd_data_o & 32'hFFF8_C000) == 32'h0)); // R5
    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|(stat_q & ~mask_q & STK))); // R7
    AST_SDIO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (sdio_irq_o && ((sstat_q & ~smask_q & 16'h0006) == 16'h0)) |-> (txn_q == 16'h0001)); // R10
endmodule

bind sdh_irq_status sdh_irq_status_chk chk_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .stat_q(stat_q), .mask_q(mask_q),
    .sstat_q(sstat_q), .smask_q(smask_q), .txn_q(t_q.txn),
    .irq_o(irq_o), .sdio_irq_o(sdio_irq_o)
);

// File: tb/sdh_irq_status_tb_top.sv
module sdh_irq_status_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt = '0;
    logic [15:0] sevt = '0;
    logic        busy = 1'b0, wp = 1'b0, cd = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq, sirq;

    always #5 clk = ~clk;

    sdh_irq_status dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .sdio_evt_i(sevt),
        .cmd_busy_i(busy), .wr_prot_i(wp), .card_present_i(cd),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq), .sdio_irq_o(sirq)
    );

    typedef struct {
        int          sel;   // 0..7 read address, 8 irq_o, 9 sdio_irq_o
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_run = 0, n_fail = 0;
    bit    mon_busy = 1'b0;
    bit    done = 1'b0;

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            wait (q.size() > 0);
            mon_busy = 1'b1;
            begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                if (it.sel < 8) rd_addr = it.sel[2:0];
                #1;
                if (it.sel == 8)      act = {31'b0, irq};
                else if (it.sel == 9) act = {31'b0, sirq};
                else                  act = rd_data;
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
            mon_busy = 1'b0;
        end
    end

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic expect_val(input int sel, input logic [31:0] exp, input string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        q.push_back(it);
        wait (q.size() == 0 && !mon_busy);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] e, input logic [15:0] se);
        evt = e; sevt = se;
        cyc();
        evt = '0; sevt = '0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        // R1 reset state
        expect_val(0, 32'h0, "R1 status");
        expect_val(1, 32'hFFFF_FFFF, "R1 mask");
        expect_val(2, 32'h0, "R1 sdio status");
        expect_val(3, 32'h0000_FFFF, "R1 sdio mask");
        expect_val(4, 32'h0, "R1 txn");
        expect_val(8, 32'h0, "R1 irq");
        expect_val(9, 32'h0, "R1 sdio irq");
        // R2 response-end event sets bit 2, masked so no irq
        pulse(32'h4, 16'h0);
        expect_val(0, 32'h4, "R2 set");
        cyc();
        expect_val(0, 32'h4, "R2 sticky");
        expect_val(8, 32'h0, "R7 masked");
        // R8 unmask bit 2
        wr(3'd1, ~32'h4);
        expect_val(1, 32'hFFFF_FFFB, "R8 mask rw");
        expect_val(8, 32'h1, "R7 unmasked");
        // R3 write ones leaves bits, write zero clears
        wr(3'd0, 32'hFFFF_FFFF);
        expect_val(0, 32'h4, "R3 ones keep");
        pulse(32'h240, 16'h0);
        expect_val(0, 32'h244, "R2 multi");
        wr(3'd0, ~32'h4);
        expect_val(0, 32'h240, "R3 clear one");
        expect_val(8, 32'h0, "R7 cleared");
        // R4 clear and event same cycle
        evt = 32'h40;
        wr(3'd0, ~32'h40);
        evt = '0;
        expect_val(0, 32'h240, "R4 event wins");
        // R5 reserved bits
        pulse(32'hFFFF_C000, 16'h0);
        expect_val(0, 32'h240, "R5 reserved events");
        expect_val(5, 32'h0, "R5 addr5");
        expect_val(7, 32'h0, "R5 addr7");
        // R6 live levels
        busy = 1'b1; wp = 1'b1; cd = 1'b1;
        expect_val(0, 32'h0007_0240, "R6 live high");
        wr(3'd0, 32'h0);
        expect_val(0, 32'h0007_0000, "R6 write no effect");
        busy = 1'b0; wp = 1'b0; cd = 1'b0;
        expect_val(0, 32'h0, "R6 live low");
        // R7 irq follows mask changes
        wr(3'd1, 32'hFFFF_FFFF);
        pulse(32'h80, 16'h0);
        expect_val(8, 32'h0, "R7 overflow masked");
        wr(3'd1, ~32'h80);
        expect_val(8, 32'h1, "R7 overflow unmasked");
        wr(3'd0, ~32'h80);
        expect_val(8, 32'h0, "R7 ack drops irq");
        // R9 sdio status
        pulse(32'h0, 16'h0006);
        expect_val(2, 32'h6, "R9 set");
        wr(3'd2, ~32'h2);
        expect_val(2, 32'h4, "R9 clear");
        pulse(32'h0, 16'hFFF8);
        expect_val(2, 32'h4, "R9 reserved");
        // R10 I/O bit gating
        wr(3'd3, 32'hFFFE);
        pulse(32'h0, 16'h0001);
        expect_val(2, 32'h5, "R10 io set");
        expect_val(9, 32'h0, "R10 txn 0");
        wr(3'd4, 32'h1);
        expect_val(9, 32'h1, "R10 txn 1");
        wr(3'd4, 32'h3);
        expect_val(9, 32'h0, "R10 txn 3");
        wr(3'd4, 32'h1);
        wr(3'd2, ~32'h1);
        expect_val(9, 32'h0, "R10 io acked");
        wr(3'd3, 32'hFFFA);
        expect_val(9, 32'h1, "R10 bit2 ungated");
        wr(3'd4, 32'h0);
        expect_val(9, 32'h1, "R10 bit2 txn 0");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule